// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block carries out the stack traffic of an 8-bit processor. It handles subroutine call and return, software break, return from interrupt, and single-byte push and pull. It owns the program counter, the 8-bit stack pointer and the status register. A command is chosen from six codes and carries a register selector, a data byte, the current program counter and a target address. The block then makes one access per cycle on a byte-wide memory port until the command is complete, and pulses `done` once.

The stack sits in page 1: every stack access goes to `{STACK_PAGE, pointer}`. A push writes at the pointer and then moves it down. A pull moves the pointer up first and then reads. Memory reads are asynchronous: `mem_rdata` must reflect `mem_addr` in the same cycle that `mem_re` is high.

Commands enter on a valid/ready handshake. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance through the `done` cycle. A command held on the inputs during that time is not queued and has no effect. The caller must keep presenting it, or drop it. Pulled bytes leave on `pull_data` with `pull_dst`, and they are valid in the `done` cycle of a pull.

Top module: `stack_seq`

## Requirements
- R1: After reset: `cmd_ready`=1, `done`=0, `mem_we`=0, `mem_re`=0, `sp`=SP_INIT (0xFD), `pc`=PC_INIT (0x0000) and `status`=STATUS_INIT (0x34).
- R2: The command codes are call=0, return=1, break=2, interrupt-return=3, push=4 and pull=5. A command is accepted only when `cmd_valid` and `cmd_ready` are both high. Codes 6 and 7 cause no access, no `done` and no state change. Commands presented while `cmd_ready` is low are ignored.
- R3: A stack write goes to 0x0100+SP and then SP decrements. A stack read goes to 0x0100+SP+1 and SP takes that incremented value. SP wraps modulo 256.
- R4: An accepted command with N accesses makes them in the N cycles after acceptance. `done` is high for exactly the next cycle, and `cmd_ready` returns in the cycle after that.
- R5: Call writes (cmd_pc−1) high byte then low byte, and then sets `pc` to `cmd_target`.
- R6: Return reads the low byte then the high byte, and sets `pc` to that word plus 1, modulo 2^16.
- R7: Break writes (cmd_pc+1) high then low, then writes the status with bits 5 and 4 set. It then reads the vector low byte at 0xFFFE and the high byte at 0xFFFF, loads `pc` from them, and sets I (status bit 2).
- R8: With CLEAR_D_ON_BRK=1, break clears D (status bit 3). With 0, D keeps its value.
- R9: Interrupt-return reads the status first and then the low and high bytes of `pc`, with no adjustment. The restored status has bits 5 and 4 forced to 1.
- R10: Push with `cmd_reg` 0, 1 or 2 (A, X or Y) writes `cmd_data`. Push with `cmd_reg`=3 writes the status OR 0x30.
- R11: Pull puts the read byte on `pull_data` and `cmd_reg` on `pull_dst`. For `cmd_reg` 0 to 2, Z (bit 1) is set when the byte is zero and N (bit 7) copies byte bit 7, and the other status bits are unchanged. For `cmd_reg`=3, the status becomes byte OR 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 3 | Command code |
| cmd_reg | input | 2 | Register selector: 0 A, 1 X, 2 Y, 3 status |
| cmd_data | input | 8 | Byte to push for A/X/Y |
| cmd_pc | input | 16 | Current program counter for call/break |
| cmd_target | input | 16 | Call destination |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Asynchronous read data |
| done | output | 1 | One-cycle completion pulse |
| pull_data | output | 8 | Byte read by the last pull |
| pull_dst | output | 2 | Register selector of the last command |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status register (N V 1 B D I Z C, bit 7 down to 0) |

## Verification
The bench builds the default instance with CLEAR_D_ON_BRK=1 and SP_INIT=0xFD. Beside it runs a twin with CLEAR_D_ON_BRK=0, fed the same commands, so a break with D set shows both variants of R8 side by side. The start pointer of 0xFD is close to the top of the page. A short run of pulls therefore carries SP across 0xFF→0x00, and the next push brings it back to 0xFF at address 0x0100. A return of 0xFFFF exercises the 16-bit wrap of the +1 adjustment.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int STEP_W = 3;

  localparam logic [2:0] OP_CALL = 3'd0;
  localparam logic [2:0] OP_RET  = 3'd1;
  localparam logic [2:0] OP_BRK  = 3'd2;
  localparam logic [2:0] OP_RTI  = 3'd3;
  localparam logic [2:0] OP_PUSH = 3'd4;
  localparam logic [2:0] OP_PULL = 3'd5;

  localparam logic [1:0] SEL_STATUS = 2'd3;

  localparam int FL_Z = 1;
  localparam int FL_I = 2;
  localparam int FL_D = 3;
  localparam int FL_N = 7;
  localparam logic [DATA_W-1:0] FORCED_BITS = 8'h30;

  typedef enum logic [3:0] {
    ACT_W_HI, ACT_W_LO, ACT_W_STAT, ACT_W_BYTE,
    ACT_R_STAT, ACT_R_LO, ACT_R_HI, ACT_R_BYTE,
    ACT_R_VLO, ACT_R_VHI
  } act_e;
endpackage

// File: rtl/seq_step_decode.sv
module seq_step_decode
  import stack_seq_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [STEP_W-1:0] step,
  output act_e              act,
  output logic              last
);
  always_comb begin
    act  = ACT_R_BYTE;
    last = 1'b1;
    case (op)
      OP_CALL: begin
        act  = (step == 0) ? ACT_W_HI : ACT_W_LO;
        last = (step != 0);
      end
      OP_RET: begin
        act  = (step == 0) ? ACT_R_LO : ACT_R_HI;
        last = (step != 0);
      end
      OP_BRK: begin
        last = 1'b0;
        case (step)
          3'd0:    act = ACT_W_HI;
          3'd1:    act = ACT_W_LO;
          3'd2:    act = ACT_W_STAT;
          3'd3:    act = ACT_R_VLO;
          default: begin act = ACT_R_VHI; last = 1'b1; end
        endcase
      end
      OP_RTI: begin
        last = 1'b0;
        case (step)
          3'd0:    act = ACT_R_STAT;
          3'd1:    act = ACT_R_LO;
          default: begin act = ACT_R_HI; last = 1'b1; end
        endcase
      end
      OP_PUSH: act = ACT_W_BYTE;
      default: act = ACT_R_BYTE;
    endcase
  end
endmodule

// File: rtl/sp_unit.sv
module sp_unit #(
  parameter int          SP_W    = 8,
  parameter logic [SP_W-1:0] SP_INIT = 8'hFD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec,
  input  logic            inc,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up
);
  logic [SP_W-1:0] sp_q;

  assign sp    = sp_q;
  assign sp_up = sp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)   sp_q <= SP_INIT;
    else if (dec) sp_q <= sp_q - 1'b1;
    else if (inc) sp_q <= sp_up;
  end

  assert_push_moves_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> sp == $past(sp) - 1'b1);
  assert_pull_moves_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> sp == $past(sp) + 1'b1);
  assert_sp_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(sp));
endmodule

// File: rtl/status_unit.sv
module status_unit
  import stack_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0] STATUS_INIT    = 8'h34,
  parameter bit                CLEAR_D_ON_BRK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              zn_en,
  input  logic [DATA_W-1:0] zn_val,
  input  logic              brk_en,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0] st_q;
  assign status = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= STATUS_INIT;
    else if (load_en) st_q <= load_val | FORCED_BITS;
    else if (zn_en) begin
      st_q[FL_Z] <= (zn_val == '0);
      st_q[FL_N] <= zn_val[DATA_W-1];
    end else if (brk_en) begin
      st_q[FL_I] <= 1'b1;
      if (CLEAR_D_ON_BRK) st_q[FL_D] <= 1'b0;
    end
  end

  assert_brk_sets_i_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_en |=> status[FL_I]);

  generate
    if (CLEAR_D_ON_BRK) begin : g_cmos
      assert_brk_clears_d_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_en |=> !status[FL_D]);
    end else begin : g_keep
      assert_brk_keeps_d_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_en |=> status[FL_D] == $past(status[FL_D]));
    end
  endgenerate

  assert_restore_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> status[5:4] == 2'b11);
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [7:0]        STACK_PAGE     = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_ADDR       = 16'hFFFE,
  parameter logic [7:0]        SP_INIT        = 8'hFD,
  parameter logic [ADDR_W-1:0] PC_INIT        = 16'h0000,
  parameter logic [DATA_W-1:0] STATUS_INIT    = 8'h34,
  parameter bit                CLEAR_D_ON_BRK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_reg,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [ADDR_W-1:0] cmd_pc,
  input  logic [ADDR_W-1:0] cmd_target,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] pull_data,
  output logic [1:0]        pull_dst,
  output logic [ADDR_W-1:0] pc,
  output logic [7:0]        sp,
  output logic [DATA_W-1:0] status
);
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_ADDR + 1'b1;

  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q;
  logic [2:0]        op_q;
  logic [1:0]        reg_q;
  logic [ADDR_W-1:0] ret_q, tgt_q, pc_q;
  logic [DATA_W-1:0] byte_q, lo_q, pull_q;
  logic [7:0]        sp_up;
  act_e              act;
  logic              last, is_wr, is_stack_rd, accept;

  assign cmd_ready = !busy_q && !done_q;
  assign accept    = cmd_valid && cmd_ready && (cmd_op <= OP_PULL);
  assign done      = done_q;
  assign pc        = pc_q;
  assign pull_data = pull_q;
  assign pull_dst  = reg_q;

  seq_step_decode u_dec (.op(op_q), .step(step_q), .act(act), .last(last));

  always_comb begin
    is_wr       = act inside {ACT_W_HI, ACT_W_LO, ACT_W_STAT, ACT_W_BYTE};
    is_stack_rd = act inside {ACT_R_STAT, ACT_R_LO, ACT_R_HI, ACT_R_BYTE};
  end

  assign mem_we = busy_q && is_wr;
  assign mem_re = busy_q && !is_wr;

  always_comb begin
    case (act)
      ACT_R_VLO: mem_addr = VEC_ADDR;
      ACT_R_VHI: mem_addr = VEC_HI_ADDR;
      default:   mem_addr = is_wr ? {STACK_PAGE, sp} : {STACK_PAGE, sp_up};
    endcase
    case (act)
      ACT_W_HI:   mem_wdata = ret_q[ADDR_W-1:DATA_W];
      ACT_W_LO:   mem_wdata = ret_q[DATA_W-1:0];
      ACT_W_STAT: mem_wdata = status | FORCED_BITS;
      default:    mem_wdata = byte_q;
    endcase
  end

  sp_unit #(.SP_W(8), .SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .dec(busy_q && is_wr), .inc(busy_q && is_stack_rd),
    .sp(sp), .sp_up(sp_up)
  );

  logic st_load, st_zn, st_brk;
  assign st_load = busy_q && ((act == ACT_R_STAT) ||
                              (act == ACT_R_BYTE && reg_q == SEL_STATUS));
  assign st_zn   = busy_q && act == ACT_R_BYTE && reg_q != SEL_STATUS;
  assign st_brk  = busy_q && act == ACT_R_VHI;

  status_unit #(.STATUS_INIT(STATUS_INIT), .CLEAR_D_ON_BRK(CLEAR_D_ON_BRK)) u_st (
    .clk(clk), .rst_n(rst_n),
    .load_en(st_load), .load_val(mem_rdata),
    .zn_en(st_zn), .zn_val(mem_rdata),
    .brk_en(st_brk), .status(status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      op_q   <= OP_PUSH;
      reg_q  <= '0;
      ret_q  <= '0;
      tgt_q  <= '0;
      byte_q <= '0;
      lo_q   <= '0;
      pull_q <= '0;
      pc_q   <= PC_INIT;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        op_q   <= cmd_op;
        reg_q  <= cmd_reg;
        tgt_q  <= cmd_target;
        ret_q  <= (cmd_op == OP_CALL) ? cmd_pc - 1'b1 : cmd_pc + 1'b1;
        byte_q <= (cmd_reg == SEL_STATUS) ? (status | FORCED_BITS) : cmd_data;
      end else if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        case (act)
          ACT_R_LO, ACT_R_VLO: lo_q <= mem_rdata;
          ACT_R_HI: pc_q <= (op_q == OP_RET) ? {mem_rdata, lo_q} + 1'b1
                                             : {mem_rdata, lo_q};
          ACT_R_VHI: pc_q <= {mem_rdata, lo_q};
          ACT_R_BYTE: pull_q <= mem_rdata;
          ACT_W_LO: if (op_q == OP_CALL) pc_q <= tgt_q;
          default: ;
        endcase
      end
    end
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op <= OP_PULL) |=> !cmd_ready);
  assert_write_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[ADDR_W-1:8] == STACK_PAGE);
  assert_one_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_status_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && act == ACT_W_STAT) |-> mem_wdata[5:4] == 2'b11);
  assert_brk_i_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_BRK) |-> status[FL_I]);
endmodule

// File: tb/tb_stack_seq.sv
`timescale 1ns/1ps
module tb_stack_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_reg = '0;
  logic [7:0]  cmd_data = '0;
  logic [15:0] cmd_pc = '0, cmd_target = '0;

  logic        rdy0, rdy1, we0, we1, re0, re1, done0, done1;
  logic [15:0] a0, a1, pc0, pc1;
  logic [7:0]  wd0, wd1, rd0, rd1, pd0, pd1, sp0, sp1, st0, st1;
  logic [1:0]  dst0, dst1;
  logic [7:0]  m0 [256];
  logic [7:0]  m1 [256];

  stack_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy0),
    .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_pc(cmd_pc),
    .cmd_target(cmd_target), .mem_addr(a0), .mem_wdata(wd0), .mem_we(we0),
    .mem_re(re0), .mem_rdata(rd0), .done(done0), .pull_data(pd0),
    .pull_dst(dst0), .pc(pc0), .sp(sp0), .status(st0));

  stack_seq #(.CLEAR_D_ON_BRK(1'b0)) dut_alt (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy1),
    .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_pc(cmd_pc),
    .cmd_target(cmd_target), .mem_addr(a1), .mem_wdata(wd1), .mem_we(we1),
    .mem_re(re1), .mem_rdata(rd1), .done(done1), .pull_data(pd1),
    .pull_dst(dst1), .pc(pc1), .sp(sp1), .status(st1));

  function automatic logic [7:0] rd_model(input logic [15:0] a, input logic [7:0] pg);
    if (a == 16'hFFFE) return 8'h00;
    if (a == 16'hFFFF) return 8'hC0;
    if (a[15:8] == 8'h01) return pg;
    return 8'hEE;
  endfunction
  assign rd0 = rd_model(a0, m0[a0[7:0]]);
  assign rd1 = rd_model(a1, m1[a1[7:0]]);
  always_ff @(posedge clk) if (we0 && a0[15:8] == 8'h01) m0[a0[7:0]] <= wd0;
  always_ff @(posedge clk) if (we1 && a1[15:8] == 8'h01) m1[a1[7:0]] <= wd1;

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offer a command, wait for acceptance, return the cycle count to done.
  task automatic run_cmd(input logic [2:0] op, input logic [1:0] rg, input logic [7:0] d,
                         input logic [15:0] p, input logic [15:0] t, output int n);
    @(negedge clk);
    cmd_op = op; cmd_reg = rg; cmd_data = d; cmd_pc = p; cmd_target = t;
    cmd_valid = 1'b1;
    while (!rdy0) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    while (!done0 && n < 40) begin @(negedge clk); n++; end
  endtask

  typedef struct packed {
    logic [2:0] op; logic [1:0] rg; logic [7:0] d; logic [15:0] p; logic [15:0] t;
    logic [15:0] e_pc; logic [7:0] e_sp; logic [7:0] e_st;
    logic [8:0] e_pull; logic [8:0] m_off; logic [7:0] m_val;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{3'd0,2'd0,8'h00,16'h1234,16'h8000,16'h8000,8'hFB,8'h34,9'h000,9'h1FD,8'h12}, // R5
    '{3'd4,2'd0,8'h80,16'h0,16'h0,16'h8000,8'hFA,8'h34,9'h000,9'h1FC,8'h33},        // R5 R10
    '{3'd4,2'd3,8'h00,16'h0,16'h0,16'h8000,8'hF9,8'h34,9'h000,9'h1FA,8'h34},        // R10
    '{3'd5,2'd1,8'h00,16'h0,16'h0,16'h8000,8'hFA,8'h34,9'h134,9'h000,8'h00},        // R11
    '{3'd5,2'd0,8'h00,16'h0,16'h0,16'h8000,8'hFB,8'hB4,9'h180,9'h000,8'h00},        // R11
    '{3'd1,2'd0,8'h00,16'h0,16'h0,16'h1234,8'hFD,8'hB4,9'h000,9'h000,8'h00},        // R6
    '{3'd4,2'd2,8'h00,16'h0,16'h0,16'h1234,8'hFC,8'hB4,9'h000,9'h1FD,8'h00},        // R10
    '{3'd5,2'd2,8'h00,16'h0,16'h0,16'h1234,8'hFD,8'h36,9'h100,9'h000,8'h00},        // R11
    '{3'd4,2'd0,8'h40,16'h0,16'h0,16'h1234,8'hFC,8'h36,9'h000,9'h000,8'h00},
    '{3'd4,2'd0,8'h10,16'h0,16'h0,16'h1234,8'hFB,8'h36,9'h000,9'h000,8'h00},
    '{3'd4,2'd0,8'h09,16'h0,16'h0,16'h1234,8'hFA,8'h36,9'h000,9'h1FB,8'h09},
    '{3'd3,2'd0,8'h00,16'h0,16'h0,16'h4010,8'hFD,8'h39,9'h000,9'h000,8'h00},        // R9
    '{3'd2,2'd0,8'h00,16'h4010,16'h0,16'hC000,8'hFA,8'h35,9'h000,9'h1FB,8'h39},     // R7 R8
    '{3'd3,2'd0,8'h00,16'h0,16'h0,16'h4011,8'hFD,8'h39,9'h000,9'h000,8'h00},        // R9
    '{3'd4,2'd0,8'hFF,16'h0,16'h0,16'h4011,8'hFC,8'h39,9'h000,9'h000,8'h00},
    '{3'd4,2'd0,8'hFF,16'h0,16'h0,16'h4011,8'hFB,8'h39,9'h000,9'h000,8'h00},
    '{3'd1,2'd0,8'h00,16'h0,16'h0,16'h0000,8'hFD,8'h39,9'h000,9'h000,8'h00},        // R6 wrap
    '{3'd4,2'd0,8'hC2,16'h0,16'h0,16'h0000,8'hFC,8'h39,9'h000,9'h000,8'h00},
    '{3'd5,2'd3,8'h00,16'h0,16'h0,16'h0000,8'hFD,8'hF2,9'h1C2,9'h000,8'h00}         // R11
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ready", {31'd0, rdy0}, 32'd1);
    chk("R1 done/we/re", {29'd0, done0, we0, re0}, 32'd0);
    chk("R1 sp", {24'd0, sp0}, 32'h0FD);
    chk("R1 pc", {16'd0, pc0}, 32'h0);
    chk("R1 status", {24'd0, st0}, 32'h34);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_cmd(VT[i].op, VT[i].rg, VT[i].d, VT[i].p, VT[i].t, n);
      chk($sformatf("R4 done seen vec%0d", i), {31'd0, done0}, 32'd1);
      chk($sformatf("R5 R6 R7 R9 pc vec%0d", i), {16'd0, pc0}, {16'd0, VT[i].e_pc});
      chk($sformatf("R3 sp vec%0d", i), {24'd0, sp0}, {24'd0, VT[i].e_sp});
      chk($sformatf("R8 R11 status vec%0d", i), {24'd0, st0}, {24'd0, VT[i].e_st});
      if (VT[i].e_pull[8]) begin
        chk($sformatf("R11 pull_data vec%0d", i), {24'd0, pd0}, {24'd0, VT[i].e_pull[7:0]});
        chk($sformatf("R11 pull_dst vec%0d", i), {30'd0, dst0}, {30'd0, VT[i].rg});
      end
      if (VT[i].m_off[8])
        chk($sformatf("R3 R10 stack byte vec%0d", i), {24'd0, m0[VT[i].m_off[7:0]]},
            {24'd0, VT[i].m_val});
      if (i == 12) chk("R8 variant keeps D", {24'd0, st1}, 32'h3D);
    end

    // R4: break timing, 5 accesses then done, ready the cycle after
    run_cmd(3'd2, 2'd0, 8'h00, 16'h0000, 16'h0, n);
    chk("R4 break cycles", n, 32'd6);
    chk("R4 ready low in done", {31'd0, rdy0}, 32'd0);
    chk("R7 break pc", {16'd0, pc0}, 32'hC000);
    chk("R7 break status", {24'd0, st0}, 32'hF6);
    @(negedge clk);
    chk("R4 ready back", {31'd0, rdy0}, 32'd1);

    // R2: command held while busy is ignored
    @(negedge clk);
    cmd_op = 3'd0; cmd_pc = 16'h5000; cmd_target = 16'h6000; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 3'd4; cmd_reg = 2'd0; cmd_data = 8'h77;
    n = 0;
    while (!done0 && n < 20) begin @(negedge clk); n++; end
    cmd_valid = 1'b0;
    chk("R2 call pc", {16'd0, pc0}, 32'h6000);
    chk("R2 call sp", {24'd0, sp0}, 32'hF8);
    chk("R5 call bytes", {16'd0, m0[8'hFA], m0[8'hF9]}, 32'h4FFF);
    n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done0 || we0 || re0) n++;
    end
    chk("R2 ignored push no activity", n, 32'd0);
    chk("R2 sp unchanged", {24'd0, sp0}, 32'hF8);

    // R2: undefined code 6 is dropped
    @(negedge clk);
    cmd_op = 3'd6; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done0 || we0 || re0 || !rdy0) n++;
    end
    chk("R2 code 6 no effect", n, 32'd0);
    chk("R2 code 6 sp", {24'd0, sp0}, 32'hF8);

    // R3: pointer wraps 0xFF -> 0x00 on pull and back on push
    for (int k = 0; k < 8; k++) run_cmd(3'd5, 2'd0, 8'h00, 16'h0, 16'h0, n);
    chk("R3 wrap up", {24'd0, sp0}, 32'h00);
    run_cmd(3'd4, 2'd0, 8'h5A, 16'h0, 16'h0, n);
    chk("R3 wrap down", {24'd0, sp0}, 32'hFF);
    chk("R3 write at 0x0100", {24'd0, m0[8'h00]}, 32'h5A);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule